// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block chooses which of four DMA channels owns the transfer engine. Every channel presents a request bit and a 3-bit bandwidth-control code. The arbiter registers a one-hot grant and a valid flag. Once a channel holds the grant, it keeps it until it drops its request or pulses its re-arbitration bit.

The base ranking is fixed: channel 0 is strongest and channel 3 is weakest. A channel whose code is zero moves one step up and overtakes only its immediate lower-index neighbour. It does not move up if that neighbour's code is also zero. Two such swaps can never touch the same channel, so the resulting ranking is always a well-defined permutation of the channels. Requests that arrive together are resolved with that ranking.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt_o` is 4'b0000 and `gnt_valid_o` is 0.
- R2: When no code is zero (all codes equal, or all non-zero), simultaneous requests are granted in ascending index order, with channel 0 first. Bit i of `gnt_o` means channel i, and channel i's code sits in `bw_code_i[3i+2:3i]`.
- R3: A channel k>0 whose code is 3'b000 wins over channel k-1 when channel k-1's code is non-zero.
- R4: A zero-code channel k does not win over any channel with index below k-1. For example, channel 2 at zero loses to channel 0.
- R5: When both channel k and channel k-1 have zero codes, channel k-1 still wins.
- R6: A zero code on channel 0 does not change the ranking.
- R7: Swaps 1-over-0 and 3-over-2 may be active at the same time. The ranking is then 1, 0, 3, 2.
- R8: While the owner keeps its request high and its re-arbitration bit low, the grant stays unchanged, even against stronger requests.
- R9: When the owner drops its request, the registered grant in the following cycle goes to the best remaining requester.
- R10: When the owner pulses its `rearb_i` bit, the next grant is chosen from the other requesters. The owner is left out of that one decision, and the grant is empty if no other channel is requesting.
- R11: A `rearb_i` bit from a channel that does not own the grant has no effect.
- R12: When no request is active, the next cycle shows `gnt_o` = 0 and `gnt_valid_o` = 0.
- R13: `gnt_o` is always one-hot or zero, and `gnt_valid_o` is high exactly when it is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Per-channel request |
| bw_code_i | input | 12 | Per-channel 3-bit bandwidth-control code, channel i at [3i+2:3i] |
| rearb_i | input | 4 | Per-channel re-arbitration pulse; only the owner's bit acts |
| gnt_o | output | 4 | Registered one-hot grant |
| gnt_valid_o | output | 1 | Grant held |

## Verification
The hardest ranking to reach is two swaps active at once. That needs codes zero, non-zero, zero, non-zero on channels 1, 0, 3 and 2, so the table uses exactly that code set with several request mixes to expose every position of the 1, 0, 3, 2 order. Between table entries the bench clears all requests, so that the grant hold does not hide the ranking. The hold and re-arbitration paths are then driven by directed sequences. In these sequences a stronger channel requests while a weaker one owns the grant, and the owner's re-arbitration bit is pulsed both with and without competitors present.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned DEF_NCH  = 4;
  localparam int unsigned DEF_CW   = 3;

  // index width with a floor of one bit
  function automatic int unsigned idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/arb_swap_detect.sv
module arb_swap_detect #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 3
) (
  input  logic [NCH*CW-1:0] codes_i,
  output logic [NCH-1:0]    code_zero_o,
  output logic [NCH-1:0]    swap_up_o
);
  // swap_up_o[k]: channel k overtakes channel k-1
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign code_zero_o[k] = (codes_i[k*CW +: CW] == '0);
    if (k == 0) begin : g_first
      assign swap_up_o[k] = 1'b0;
    end else begin : g_rest
      assign swap_up_o[k] = code_zero_o[k] & ~code_zero_o[k-1];
    end
  end
endmodule

// File: rtl/arb_order_map.sv
module arb_order_map #(
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic [NCH-1:0]    swap_up_i,
  output logic [NCH*IW-1:0] order_o
);
  // order_o[p]: channel sitting at rank p (rank 0 strongest)
  for (genvar p = 0; p < NCH; p++) begin : g_pos
    logic from_above;
    logic from_below;
    if (p + 1 < NCH) begin : g_hi
      assign from_above = swap_up_i[p+1];
    end else begin : g_nohi
      assign from_above = 1'b0;
    end
    if (p > 0) begin : g_lo
      assign from_below = swap_up_i[p];
    end else begin : g_nolo
      assign from_below = 1'b0;
    end
    assign order_o[p*IW +: IW] = from_above ? IW'(p + 1) :
                                 from_below ? IW'(p - 1) : IW'(p);
  end
endmodule

// File: rtl/arb_rank_pick.sv
module arb_rank_pick #(
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic [NCH*IW-1:0] order_i,
  input  logic [NCH-1:0]    req_i,
  output logic [NCH-1:0]    win_o,
  output logic              any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    win_o = '0;
    for (int p = 0; p < NCH; p++) begin
      if (!found && req_i[order_i[p*IW +: IW]]) begin
        win_o[order_i[p*IW +: IW]] = 1'b1;
        found = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = DEF_NCH,
  parameter int unsigned CW  = DEF_CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*CW-1:0] bw_code_i,
  input  logic [NCH-1:0]    rearb_i,
  output logic [NCH-1:0]    gnt_o,
  output logic              gnt_valid_o
);
  localparam int unsigned IW = idx_width(NCH);

  logic [NCH-1:0]    code_zero_w;
  logic [NCH-1:0]    swap_up_w;
  logic [NCH*IW-1:0] order_w;
  logic [NCH-1:0]    cand_w;
  logic [NCH-1:0]    win_w;
  logic              win_any_w;
  logic              hold_w;
  logic              perm_ok_w;
  logic [NCH-1:0]    gnt_q;
  logic              vld_q;

  arb_swap_detect #(.NCH(NCH), .CW(CW)) swap_i (
    .codes_i     (bw_code_i),
    .code_zero_o (code_zero_w),
    .swap_up_o   (swap_up_w)
  );

  arb_order_map #(.NCH(NCH), .IW(IW)) order_i (
    .swap_up_i (swap_up_w),
    .order_o   (order_w)
  );

  // owner asking to re-arbitrate sits out this decision
  assign cand_w = req_i & ~(gnt_q & rearb_i);

  arb_rank_pick #(.NCH(NCH), .IW(IW)) pick_i (
    .order_i (order_w),
    .req_i   (cand_w),
    .win_o   (win_w),
    .any_o   (win_any_w)
  );

  assign hold_w = vld_q && ((gnt_q & req_i & ~rearb_i) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      vld_q <= 1'b0;
    end else if (!hold_w) begin
      gnt_q <= win_w;
      vld_q <= win_any_w;
    end
  end

  assign gnt_o       = gnt_q;
  assign gnt_valid_o = vld_q;

  // every channel must appear at exactly one rank
  function automatic logic is_perm(input logic [NCH*IW-1:0] ord);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      int unsigned hits;
      hits = 0;
      for (int p = 0; p < NCH; p++)
        if (int'(ord[p*IW +: IW]) == c) hits++;
      if (hits != 1) ok = 1'b0;
    end
    return ok;
  endfunction

  assign perm_ok_w = is_perm(order_w);

  p_order_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ok_w);

  p_swap_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_up_w & (swap_up_w >> 1)) == '0);

  p_gnt_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_valid_match_r13: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o == (gnt_o != '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && ((gnt_o & req_i & ~rearb_i) != '0)) |=> $stable(gnt_o));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> !gnt_valid_o);

  p_grant_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> ((gnt_o & $past(req_i)) != '0));

  p_rearb_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && ((gnt_o & rearb_i) != '0)) |=> ((gnt_o & $past(gnt_o)) == '0));
endmodule

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [11:0] codes = '0;
  logic [3:0]  rearb = '0;
  logic [3:0]  gnt;
  logic        gvld;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bw_code_i(codes),
    .rearb_i(rearb), .gnt_o(gnt), .gnt_valid_o(gvld)
  );

  // {req, codes c3..c0, expected grant}
  localparam logic [19:0] VEC [NV] = '{
    {4'b1111, 3'd1, 3'd1, 3'd1, 3'd1, 4'b0001}, // R2
    {4'b1110, 3'd1, 3'd1, 3'd1, 3'd1, 4'b0010}, // R2
    {4'b1110, 3'd7, 3'd7, 3'd7, 3'd7, 4'b0010}, // R2 equal codes
    {4'b0011, 3'd1, 3'd1, 3'd0, 3'd1, 4'b0010}, // R3
    {4'b0110, 3'd1, 3'd0, 3'd1, 3'd1, 4'b0100}, // R3
    {4'b1100, 3'd0, 3'd5, 3'd1, 3'd1, 4'b1000}, // R3
    {4'b0101, 3'd1, 3'd0, 3'd1, 3'd1, 4'b0001}, // R4
    {4'b0011, 3'd1, 3'd1, 3'd0, 3'd0, 4'b0001}, // R5
    {4'b0110, 3'd1, 3'd0, 3'd0, 3'd1, 4'b0010}, // R5
    {4'b0011, 3'd1, 3'd1, 3'd1, 3'd0, 4'b0001}, // R6
    {4'b1010, 3'd0, 3'd2, 3'd0, 3'd2, 4'b0010}, // R7
    {4'b1100, 3'd0, 3'd2, 3'd0, 3'd2, 4'b1000}, // R7
    {4'b1101, 3'd0, 3'd2, 3'd0, 3'd2, 4'b0001}  // R7
  };

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (gnt !== exp || gvld !== (exp != 0)) begin
      errors++;
      $display("FAIL %s gnt=%b vld=%b expected gnt=%b vld=%b",
               tag, gnt, gvld, exp, (exp != 0));
    end
  endtask

  // inputs change 1 time unit after a rising edge; outputs sampled there too
  task automatic step(input logic [3:0] r, input logic [11:0] c, input logic [3:0] a);
    req = r; codes = c; rearb = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", 4'b0000);
    rst_n = 1'b1;
    step(4'b1111, 12'o1111, 4'b0000);
    // first edge out of reset already registers a grant; reset state seen before
    step(4'b0000, 12'o1111, 4'b0000);
    check("R12 idle", 4'b0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:16], VEC[i][15:4], 4'b0000);
      check($sformatf("R2-R7 vec %0d", i), VEC[i][3:0]);
      step(4'b0000, VEC[i][15:4], 4'b0000);
      check("R12 clear", 4'b0000);
    end

    // R8 hold against stronger requester
    step(4'b0100, 12'o1111, 4'b0000);
    check("R8 grant", 4'b0100);
    step(4'b0101, 12'o1111, 4'b0000);
    check("R8 hold", 4'b0100);
    step(4'b0101, 12'o1111, 4'b0000);
    check("R8 hold again", 4'b0100);
    // R9 owner drops
    step(4'b0001, 12'o1111, 4'b0000);
    check("R9 handover", 4'b0001);
    // R11 rearb from non-owner
    step(4'b0101, 12'o1111, 4'b0100);
    check("R11 ignored", 4'b0001);
    // R10 owner rearb with competitor
    step(4'b0101, 12'o1111, 4'b0001);
    check("R10 rearb to other", 4'b0100);
    step(4'b0101, 12'o1111, 4'b0000);
    check("R10 then held", 4'b0100);
    // R10 owner rearb alone
    step(4'b0100, 12'o1111, 4'b0100);
    check("R10 rearb alone empties", 4'b0000);
    step(4'b0100, 12'o1111, 4'b0000);
    check("R10 regrant", 4'b0100);
    // R12 all drop
    step(4'b0000, 12'o1111, 4'b0000);
    check("R12 drop all", 4'b0000);
    // R1 reset mid-grant
    step(4'b0010, 12'o1111, 4'b0000);
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears", 4'b0000);
    rst_n = 1'b1;
    step(4'b0010, 12'o1111, 4'b0000);
    check("R9 after reset", 4'b0010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule